// File: doc/BRIEF.md
# Timed pin-stream command engine

This block turns a byte stream arriving from a host-side packet link into activity on a small general-purpose pin port. The pins are typically wired as a bit-banged serial flash interface: pin 0 is the active-low chip select, pin 3 is the serial clock and pin 5 is the serial data out. Pins 6 and 7 are inputs only, and pin 7 carries the serial data in. Each packet that should be interpreted starts with a stream-open byte. Every following byte is one instruction. Its two top bits choose the action: drive the output latch, set the drive-enable mask, or wait a number of microseconds. Two special codes take a snapshot of the pins or close the stream.

Every instruction occupies the same number of clock cycles. Writing the same output value several times in a row is therefore a predictable way to stretch a pulse, such as a chip-select high time. Snapshots of the pins go out on a valid/ready response port, and the engine stalls while a snapshot waits to be taken. The transport itself is abstracted as a valid/ready byte stream with a last-byte marker.

Top module: `pin_stream_engine`

## Requirements
- R1: A packet whose first byte is 0xAB opens a stream. A packet that starts with any other byte is drained up to its last byte, with no effect on pins, response or error flag.
- R2: Inside a stream, a byte of the form 0b10dddddd loads d into the 6-bit output latch `pin_out`, visible one cycle after acceptance. Reset value is 0x37: bit 0 select high, bit 3 clock low, bits 5/4/2/1 high.
- R3: Inside a stream, a byte of the form 0b01dddddd loads d into `pin_oe`, where bit value 1 means the pin is driven. Reset value is 0x00, all pins released.
- R4: Byte 0x20 inside a stream closes it. Later bytes of the same packet are treated as a new leading byte and need 0xAB again to have any effect.
- R5: Byte 0x00 inside a stream captures all 8 bits of `pin_in` into `rsp_data` at the acceptance edge and raises `rsp_valid`. Both hold, unchanged, until a cycle with `rsp_ready` high.
- R6: Every byte accepted inside a stream holds `in_ready` low for INSTR_CYCLES-1 cycles after its acceptance edge. No byte is accepted while `rsp_valid` is high.
- R7: A byte of the form 0b11nnnnnn inside a stream holds `in_ready` low for a further n*(CLK_HZ/1e6) cycles, so that the next acceptance comes INSTR_CYCLES + n*CLK_HZ/1e6 cycles later.
- R8: Any other byte of the form 0b00xxxxxx inside a stream changes no pin and sets `err`. `err` stays set until reset and is 0 after reset.
- R9: A byte accepted with `in_last` high ends any open stream, so the next packet needs its own 0xAB.
- R10: Bytes beyond the first MAX_PKT of a packet are dropped without effect on pins, and each one sets `err`. The count restarts after every `in_last`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| rsp_valid | output | 1 | Snapshot byte pending |
| rsp_data | output | 8 | Snapshot of the pins |
| rsp_ready | input | 1 | Consumer takes the snapshot |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_out | output | 6 | Output latch for pins 0..5 |
| pin_oe | output | 6 | Drive enable for pins 0..5 |
| err | output | 1 | Sticky protocol error |

## Verification
The stream is exercised with a well-formed packet that writes outputs and directions. Further cases cover a packet with a foreign leading byte, which separates a rejected stream from an accepted one, and bytes placed after the terminator and across packet ends, which show whether the stream state is cleared. A delay byte is followed by plain output writes, and the acceptance spacing between them distinguishes the fixed instruction time from the microsecond wait. Snapshots are taken while the consumer withholds ready and the pins change, which shows that capture happens at acceptance and that the engine stalls. An over-long packet and an unknown code check the error flag and the dropping of excess bytes.

// File: rtl/pin_stream_engine.sv
module pin_stream_engine #(
  parameter int CLK_HZ       = 250_000_000,
  parameter int INSTR_CYCLES = 188,
  parameter int MAX_PKT      = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       rsp_ready,
  input  logic [7:0] pin_in,
  output logic [5:0] pin_out,
  output logic [5:0] pin_oe,
  output logic       err
);

  localparam int US_CYCLES = CLK_HZ / 1_000_000;
  localparam int IW = $clog2(INSTR_CYCLES + 1);
  localparam int PW = $clog2(US_CYCLES + 1);
  localparam int XW = $clog2(MAX_PKT + 1);
  localparam logic [XW-1:0] MAXV  = XW'(MAX_PKT);
  localparam logic [IW-1:0] ILOAD = IW'(INSTR_CYCLES - 1);
  localparam logic [PW-1:0] PLOAD = PW'(US_CYCLES - 1);
  localparam logic [7:0] HDR  = 8'hAB;
  localparam logic [7:0] TERM = 8'h20;
  localparam logic [7:0] SMP  = 8'h00;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SKIP} st_t;
  st_t st;

  logic [IW-1:0] icnt;
  logic [5:0]    ucnt;
  logic [PW-1:0] pcnt;
  logic [XW-1:0] idx;

  logic busy, take, over, exec;
  logic is_out, is_dir, is_dly, is_smp, is_end, is_bad;

  assign busy     = (icnt != '0) || (ucnt != '0);
  assign in_ready = !busy && !rsp_valid;
  assign take     = in_valid && in_ready;
  assign over     = idx >= MAXV;
  assign exec     = take && !over && (st == S_RUN);

  assign is_out = exec && (in_data[7:6] == 2'b10);
  assign is_dir = exec && (in_data[7:6] == 2'b01);
  assign is_dly = exec && (in_data[7:6] == 2'b11);
  assign is_smp = exec && (in_data == SMP);
  assign is_end = exec && (in_data == TERM);
  assign is_bad = exec && (in_data[7:6] == 2'b00) && !is_smp && !is_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
      ucnt <= '0;
      pcnt <= '0;
    end else if (exec) begin
      icnt <= ILOAD;
      ucnt <= is_dly ? in_data[5:0] : 6'd0;
      pcnt <= PLOAD;
    end else if (icnt != '0) begin
      icnt <= icnt - 1'b1;
    end else if (ucnt != '0) begin
      if (pcnt == '0) begin
        pcnt <= PLOAD;
        ucnt <= ucnt - 1'b1;
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else if (take) begin
      idx <= in_last ? '0 : (over ? idx : idx + 1'b1);
      if (in_last) st <= S_IDLE;
      else if (!over) begin
        case (st)
          S_IDLE:  st <= (in_data == HDR) ? S_RUN : S_SKIP;
          S_RUN:   if (is_end) st <= S_IDLE;
          default: st <= st;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= 6'h37;
      pin_oe  <= 6'h00;
    end else begin
      if (is_out) pin_out <= in_data[5:0];
      if (is_dir) pin_oe  <= in_data[5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (is_smp) begin
      rsp_valid <= 1'b1;
      rsp_data  <= pin_in;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if ((take && over) || is_bad) err <= 1'b1;
  end

  p_out_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(in_valid && in_ready && in_data[7:6] == 2'b10));

  p_oe_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(in_valid && in_ready && in_data[7:6] == 2'b01));

  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_end |=> (st == S_IDLE));

  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (INSTR_CYCLES > 1)) |=> !in_ready);

  p_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  p_err_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> (st == S_IDLE));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && over) |=> ($stable(pin_out) && $stable(pin_oe) && err));

endmodule

// File: tb/pin_stream_engine_test.sv
module pin_stream_engine_test;
  localparam int CLK_HZ = 250_000_000;
  localparam int INSTR  = 188;
  localparam int MAXP   = 32;
  localparam int US     = CLK_HZ / 1_000_000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, rsp_ready = 1;
  logic [7:0] in_data = 0, pin_in = 0;
  logic in_ready, rsp_valid, err;
  logic [7:0] rsp_data;
  logic [5:0] pin_out, pin_oe;

  always #2 clk = ~clk;

  pin_stream_engine #(.CLK_HZ(CLK_HZ), .INSTR_CYCLES(INSTR), .MAX_PKT(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .err(err));

  int checks = 0, errors = 0;
  longint tcyc = 0;
  bit done = 0;

  // behavioural reference: stream mode 0 idle, 1 open, 2 draining
  longint cyc = 0, free_at = 0;
  int m_st = 0, m_idx = 0;
  logic [5:0] m_out = 6'h37, m_oe = 0;
  logic m_rv = 0, m_err = 0;
  logic [7:0] m_rd = 0;

  always @(posedge clk) begin
    tcyc++;
    if (!rst_n) begin
      cyc = 0; free_at = 0; m_st = 0; m_idx = 0;
      m_out = 6'h37; m_oe = 0; m_rv = 0; m_err = 0; m_rd = 0;
    end else begin
      bit acc;
      acc = in_valid && (cyc >= free_at) && !m_rv;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        if (m_idx >= MAXP) m_err = 1;
        else if (m_st == 0) m_st = (in_data == 8'hAB) ? 1 : 2;
        else if (m_st == 1) begin
          free_at = cyc + INSTR;
          case (in_data[7:6])
            2'b10: m_out = in_data[5:0];
            2'b01: m_oe = in_data[5:0];
            2'b11: free_at = free_at + longint'(in_data[5:0]) * US;
            default: begin
              if (in_data == 8'h00) begin m_rv = 1; m_rd = pin_in; end
              else if (in_data == 8'h20) m_st = 0;
              else m_err = 1;
            end
          endcase
        end
        if (in_last) begin m_st = 0; m_idx = 0; end
        else if (m_idx < MAXP) m_idx++;
      end
      cyc++;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, tcyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_out vs model", pin_out, m_out);
      chk("R3 pin_oe vs model", pin_oe, m_oe);
      chk("R6/R7 in_ready vs model", in_ready, (cyc >= free_at) && !m_rv);
      chk("R5 rsp_valid vs model", rsp_valid, m_rv);
      if (m_rv) chk("R5 rsp_data vs model", rsp_data, m_rd);
      chk("R8 err vs model", err, m_err);
    end
  end

  longint acc_at;

  task automatic send(input logic [7:0] b, input logic last);
    in_valid = 1; in_data = b; in_last = last;
    forever begin
      bit got;
      got = in_ready;
      @(negedge clk);
      if (got) break;
    end
    acc_at = tcyc;
    in_valid = 0; in_last = 0;
  endtask

  task automatic settle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint t0;
    do_reset();
    chk("R2 reset pin_out", pin_out, 6'h37);
    chk("R3 reset pin_oe", pin_oe, 0);
    chk("R8 reset err", err, 0);
    chk("R5 reset rsp_valid", rsp_valid, 0);

    send(8'hAB, 0); send(8'hB6, 0); send(8'h7F, 0); send(8'hAA, 0); send(8'h20, 1);
    settle();
    chk("R2 output write", pin_out, 6'h2A);
    chk("R3 direction write", pin_oe, 6'h3F);

    send(8'h13, 0); send(8'h80, 0); send(8'h45, 1);
    settle();
    chk("R1 foreign header pin_out", pin_out, 6'h2A);
    chk("R1 foreign header pin_oe", pin_oe, 6'h3F);
    chk("R1 foreign header err", err, 0);

    send(8'hAB, 0); send(8'h81, 0); send(8'h20, 0); send(8'h8F, 0); send(8'h4F, 1);
    settle();
    chk("R4 after terminator pin_out", pin_out, 6'h01);
    chk("R4 after terminator pin_oe", pin_oe, 6'h3F);

    send(8'hAB, 0); send(8'h85, 1);
    send(8'h87, 1);
    settle();
    chk("R9 stream closed at packet end", pin_out, 6'h05);

    send(8'hAB, 0); send(8'hC3, 0); t0 = acc_at;
    send(8'hB7, 0);
    chk("R7 delay spacing", acc_at - t0, INSTR + 3 * US);
    t0 = acc_at;
    send(8'hB7, 0);
    chk("R6 instruction spacing", acc_at - t0, INSTR);
    send(8'h20, 1);
    settle();

    pin_in = 8'hA5; rsp_ready = 0;
    send(8'hAB, 0); send(8'h00, 0);
    pin_in = 8'h3C;
    repeat (INSTR + 20) @(negedge clk);
    chk("R5 snapshot held", rsp_valid, 1);
    chk("R5 snapshot data", rsp_data, 8'hA5);
    chk("R6 stall while response pending", in_ready, 0);
    rsp_ready = 1;
    send(8'h00, 0);
    @(negedge clk);
    chk("R5 second snapshot", rsp_data, 8'h3C);
    send(8'h20, 1);
    settle();

    send(8'hAB, 0); send(8'h05, 0); send(8'h20, 1);
    settle();
    chk("R8 unknown code sets err", err, 1);
    chk("R8 unknown code no pin change", pin_out, 6'h37);

    do_reset();
    chk("R8 err cleared by reset", err, 0);
    send(8'hAB, 0);
    for (int k = 1; k <= 31; k++) send(8'h80 | 8'(k), 0);
    send(8'h7F, 0); send(8'h80, 1);
    settle();
    chk("R10 pin_out after overflow", pin_out, 6'h1F);
    chk("R10 pin_oe after overflow", pin_oe, 6'h00);
    chk("R10 overflow sets err", err, 1);
    send(8'hAB, 0); send(8'h82, 1);
    settle();
    chk("R10 count restarts next packet", pin_out, 6'h02);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule